// File: doc/BRIEF.md
# Dual-Clock FIFO with Mode-Selectable Status Flags

This block carries 36-bit words from a producer clock domain to a consumer clock domain. Words are written on `wr_clk` and read on `rd_clk`. The producer sees one status output, `wr_ready`, which is high while at least one storage location is free. The consumer sees one status output, `rd_ready`. The meaning of `rd_ready`, and the point at which read data appears, depend on a timing-mode input.

In standard timing (`fwft_mode` = 0), `rd_ready` works as a not-empty indication. A read request loads the next word into the registered `rd_data` output on the read-clock edge that accepts it.

In first-word-fall-through timing (`fwft_mode` = 1), the next word is moved into the output register without any request. `rd_ready` then means "`rd_data` holds a valid word", and a read request takes that word away. A word sitting in the output register counts as already removed from storage, so it no longer occupies a memory location.

Each domain compares its own binary-counted pointer against a Gray-coded copy of the other domain's pointer. That copy is brought across through a chain of `SYNC_STAGES` flip-flops, two by default. A flag therefore releases only after the event on the other port has crossed that chain. The mode input is treated as static: it is changed only while `rst_n` is held low.

Top module: `dcf_fifo`

## Requirements
- R1: While and after an asynchronous reset (`rst_n` low), `rd_ready` is 0, `wr_ready` is 1 and `rd_data` is all zeros.
- R2: In standard mode a read is accepted when `rd_en` and `rd_ready` are both 1 at a `rd_clk` rising edge. The next word in write order appears on `rd_data` at that same edge, and the read pointer advances.
- R3: A write is accepted only when `wr_en` and `wr_ready` are both 1 at a `wr_clk` rising edge. When `wr_ready` is 0, a write attempt leaves storage and the write pointer unchanged. In standard mode `wr_ready` falls after exactly DEPTH accepted writes with no reads.
- R4: In standard mode, `rd_en` while `rd_ready` is 0 has no effect: `rd_data` and the read pointer stay unchanged.
- R5: In standard mode, after a word is written into an empty FIFO, `rd_ready` rises on the second `rd_clk` rising edge that follows the write edge.
- R6: After a read from a full FIFO, `wr_ready` rises on the second `wr_clk` rising edge that follows the read edge.
- R7: In first-word-fall-through mode, a word written into an empty FIFO is shown on `rd_data` with `rd_ready` = 1 from the third `rd_clk` rising edge after the write. While `rd_ready` = 1 and `rd_en` = 0, `rd_data` and `rd_ready` hold their values. `rd_en` with `rd_ready` = 1 removes the shown word.
- R8: In first-word-fall-through mode the word in the output register frees its memory location. With no reads, after the flags have settled, DEPTH writes still leave `wr_ready` at 1, and DEPTH+1 writes make it 0.
- R9: The Gray-coded write pointer and read pointer, which are the values that cross domains, each change in at most one bit per clock of their own domain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fwft_mode | input | 1 | 1 = first-word-fall-through timing, 0 = standard timing; static outside reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Word to store |
| wr_ready | output | 1 | High while a location is free (input-ready / not-full) |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Registered output word |
| rd_ready | output | 1 | Standard: data stored; fall-through: `rd_data` valid |

## Verification
The assertions check on every cycle that:
- a refused write leaves the write pointer unchanged;
- an empty read in standard mode changes nothing;
- an accepted standard read always advances the read pointer;
- a shown word in fall-through mode stays put until it is taken;
- both Gray pointers move by one bit at most.

Only the bench scenarios can show:
- the exact two-edge and three-edge release latencies;
- the capacity difference between the two modes;
- the preservation of write order across a long random mix of reads and writes with refused attempts.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

   typedef enum logic {
      DCF_STD  = 1'b0,
      DCF_FWFT = 1'b1
   } dcf_mode_e;

   function automatic int dcf_ptr_bits(input int depth);
      return $clog2(depth) + 1;
   endfunction

endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stage_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         logic [W-1:0] src;
         if (s == 0) begin : g_first
            assign src = d;
         end else begin : g_next
            assign src = stage_q[s-1];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= src;
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl #(
   parameter int PW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [PW-1:0] rgray_s,
   output logic          wr_ready,
   output logic          wr_fire,
   output logic [PW-2:0] waddr,
   output logic [PW-1:0] wgray
);

   logic [PW-1:0] wbin;
   logic [PW-1:0] wbin_nx;
   logic          full;

   // Full: Gray pointers differ only in their two upper bits.
   assign full     = (wgray == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
   assign wr_ready = ~full;
   assign wr_fire  = wr_en & ~full;
   assign wbin_nx  = wbin + PW'(1);
   assign waddr    = wbin[PW-2:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wr_fire) begin
         wbin  <= wbin_nx;
         wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
   import dcf_pkg::*;
#(
   parameter int PW    = 5,
   parameter int WIDTH = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fwft_mode,
   input  logic             rd_en,
   input  logic [PW-1:0]    wgray_s,
   input  logic [WIDTH-1:0] mem_word,
   output logic [PW-2:0]    raddr,
   output logic [PW-1:0]    rgray,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_ready
);

   dcf_mode_e     mode;
   logic [PW-1:0] rbin;
   logic [PW-1:0] rbin_nx;
   logic          mem_ne;
   logic          out_full;
   logic          take;

   assign mode    = dcf_mode_e'(fwft_mode);
   assign mem_ne  = (rgray != wgray_s);
   assign rbin_nx = rbin + PW'(1);
   assign raddr   = rbin[PW-2:0];

   // Fall-through refills a vacant (or departing) output slot on its own.
   always_comb begin
      if (mode == DCF_FWFT) begin
         take     = mem_ne && (!out_full || rd_en);
         rd_ready = out_full;
      end else begin
         take     = rd_en && mem_ne;
         rd_ready = mem_ne;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin     <= '0;
         rgray    <= '0;
         rd_data  <= '0;
         out_full <= 1'b0;
      end else begin
         if (take) begin
            rbin    <= rbin_nx;
            rgray   <= rbin_nx ^ (rbin_nx >> 1);
            rd_data <= mem_word;
         end
         if (mode != DCF_FWFT) out_full <= 1'b0;
         else if (take)        out_full <= 1'b1;
         else if (rd_en)       out_full <= 1'b0;
      end
   end

endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
   import dcf_pkg::*;
#(
   parameter int WIDTH       = 36,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             wr_clk,
   input  logic             rd_clk,
   input  logic             rst_n,
   input  logic             fwft_mode,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic             wr_ready,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_ready
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = dcf_ptr_bits(DEPTH);

   generate
      if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("dcf_fifo: DEPTH must be a power of two, at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dcf_fifo: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wr_gray, rd_gray, wr_gray_rs, rd_gray_ws;
   logic [AW-1:0]    waddr, raddr;
   logic             wr_fire;

   dcf_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk(wr_clk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_ws)
   );

   dcf_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk(rd_clk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_rs)
   );

   dcf_wr_ctrl #(.PW(PW)) u_wr (
      .clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .rgray_s(rd_gray_ws),
      .wr_ready(wr_ready), .wr_fire(wr_fire), .waddr(waddr), .wgray(wr_gray)
   );

   dcf_rd_ctrl #(.PW(PW), .WIDTH(WIDTH)) u_rd (
      .clk(rd_clk), .rst_n(rst_n), .fwft_mode(fwft_mode), .rd_en(rd_en),
      .wgray_s(wr_gray_rs), .mem_word(mem[raddr]), .raddr(raddr),
      .rgray(rd_gray), .rd_data(rd_data), .rd_ready(rd_ready)
   );

   always_ff @(posedge wr_clk) begin
      if (wr_fire) mem[waddr] <= wr_data;
   end

endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
   parameter int PW    = 5,
   parameter int WIDTH = 36
) (
   input logic             wr_clk,
   input logic             rd_clk,
   input logic             rst_n,
   input logic             fwft_mode,
   input logic             wr_en,
   input logic             wr_ready,
   input logic             rd_en,
   input logic             rd_ready,
   input logic [WIDTH-1:0] rd_data,
   input logic [PW-1:0]    wgray,
   input logic [PW-1:0]    rgray
);

   p_refused_write_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_en && !wr_ready) |=> $stable(wgray));

   p_idle_read_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!fwft_mode && rd_en && !rd_ready) |=> ($stable(rgray) && $stable(rd_data)));

   p_std_read_moves_r2: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!fwft_mode && rd_en && rd_ready) |=> (rgray != $past(rgray)));

   p_fwft_hold_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (fwft_mode && rd_ready && !rd_en) |=> (rd_ready && $stable(rd_data)));

   p_wgray_step_r9: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $countones(wgray ^ $past(wgray)) <= 1);

   p_rgray_step_r9: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $countones(rgray ^ $past(rgray)) <= 1);

endmodule

bind dcf_fifo dcf_fifo_chk #(.PW(PW), .WIDTH(WIDTH)) u_chk (
   .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .fwft_mode(fwft_mode),
   .wr_en(wr_en), .wr_ready(wr_ready), .rd_en(rd_en), .rd_ready(rd_ready),
   .rd_data(rd_data), .wgray(wr_gray), .rgray(rd_gray)
);

// File: tb/dcf_fifo_test.sv
module dcf_fifo_test;

   localparam int DEPTH = 16;

   logic        wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0, fwft_mode = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [35:0] wr_data = '0;
   logic [35:0] rd_data;
   logic        wr_ready, rd_ready;

   int errors = 0, checks = 0;
   logic [35:0] q[$];

   always #2 wr_clk = ~wr_clk;
   initial begin
      #3;
      forever begin rd_clk = 1'b1; #3; rd_clk = 1'b0; #3; end
   end

   dcf_fifo #(.WIDTH(36), .DEPTH(DEPTH), .SYNC_STAGES(2)) uut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .fwft_mode(fwft_mode),
      .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
      .rd_en(rd_en), .rd_data(rd_data), .rd_ready(rd_ready)
   );

   task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [35:0] rnd_word();
      return {4'($urandom), 32'($urandom)};
   endfunction

   task automatic do_reset(input logic m);
      rst_n = 1'b0; fwft_mode = m; wr_en = 1'b0; rd_en = 1'b0;
      q.delete();
      repeat (3) @(negedge wr_clk);
      rst_n = 1'b1;
      repeat (2) @(negedge rd_clk);
   endtask

   task automatic writer(input int nwr, input int pct);
      int put = 0;
      while (put < nwr) begin
         @(negedge wr_clk);
         wr_en = 1'b0;
         if (($urandom % 100) < pct) begin
            wr_data = rnd_word();
            wr_en   = 1'b1;
            if (wr_ready) begin q.push_back(wr_data); put++; end
         end
      end
      @(negedge wr_clk);
      wr_en = 1'b0;
   endtask

   // R2 / R7: reads compared with the model queue; rd_en also raised while not ready (R4)
   task automatic reader(input int nrd, input int pct);
      int got = 0;
      bit pend = 0;
      logic [35:0] pexp = '0;
      while (got < nrd) begin
         @(negedge rd_clk);
         if (pend) begin chk(rd_data == pexp, "R2 std read data", rd_data, pexp); pend = 0; end
         rd_en = (($urandom % 100) < pct);
         if (fwft_mode && rd_ready)
            chk(rd_data == q[0], "R7 fwft shown word", rd_data, q[0]);
         if (rd_en && rd_ready) begin
            if (fwft_mode) void'(q.pop_front());
            else begin pexp = q.pop_front(); pend = 1; end
            got++;
         end
      end
      @(negedge rd_clk);
      if (pend) chk(rd_data == pexp, "R2 std read data", rd_data, pexp);
      rd_en = 1'b0;
   endtask

   task automatic lat_write(input logic [35:0] v, input int expn, input string req);
      int n = 0;
      @(negedge wr_clk);
      wr_data = v; wr_en = 1'b1; q.push_back(v);
      @(posedge wr_clk);
      fork begin @(negedge wr_clk); wr_en = 1'b0; end join_none
      do begin @(posedge rd_clk); #1; n++; end while (!rd_ready && n < 10);
      chk(n == expn, req, 36'(n), 36'(expn));
   endtask

   task automatic lat_read_full();
      int n = 0;
      logic [35:0] e;
      @(negedge rd_clk);
      rd_en = 1'b1; e = q.pop_front();
      @(posedge rd_clk);
      fork begin @(negedge rd_clk); rd_en = 1'b0; end join_none
      do begin @(posedge wr_clk); #1; n++; end while (!wr_ready && n < 10);
      chk(n == 2, "R6 wr_ready release edges", 36'(n), 36'd2);
      @(negedge rd_clk);
      chk(rd_data == e, "R2 read from full", rd_data, e);
   endtask

   task automatic empty_reads(input string req);
      @(negedge rd_clk); rd_en = 1'b1;
      repeat (3) @(negedge rd_clk);
      rd_en = 1'b0;
      chk(rd_data == '0, req, rd_data, '0);
      chk(rd_ready == 1'b0, req, 36'(rd_ready), 36'd0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge wr_clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5eed_0f1f));

      // ---------------- standard mode ----------------
      do_reset(1'b0);
      chk(rd_ready == 1'b0, "R1 rd_ready after reset", 36'(rd_ready), 36'd0);
      chk(wr_ready == 1'b1, "R1 wr_ready after reset", 36'(wr_ready), 36'd1);
      chk(rd_data == '0, "R1 rd_data after reset", rd_data, '0);
      empty_reads("R4 empty read ignored");
      lat_write(36'h9_A5A5_0001, 2, "R5 std rd_ready release edges");
      reader(1, 100);

      writer(DEPTH, 100);
      repeat (10) @(negedge wr_clk);
      chk(wr_ready == 1'b0, "R3 full after DEPTH writes", 36'(wr_ready), 36'd0);
      repeat (3) begin
         @(negedge wr_clk); wr_en = 1'b1; wr_data = 36'hB_AD00_BAD0;
         chk(wr_ready == 1'b0, "R3 write refused while full", 36'(wr_ready), 36'd0);
      end
      @(negedge wr_clk); wr_en = 1'b0;
      lat_read_full();
      reader(DEPTH - 1, 100);
      repeat (6) @(negedge rd_clk);
      chk(rd_ready == 1'b0, "R3 refused words absent", 36'(rd_ready), 36'd0);

      fork
         writer(400, 55);
         reader(400, 45);
      join

      // ---------------- fall-through mode ----------------
      do_reset(1'b1);
      chk(rd_ready == 1'b0, "R1 fwft rd_ready after reset", 36'(rd_ready), 36'd0);
      chk(wr_ready == 1'b1, "R1 fwft wr_ready after reset", 36'(wr_ready), 36'd1);
      empty_reads("R7 fwft empty read ignored");
      lat_write(36'h3_C0DE_0042, 3, "R7 fwft rd_ready release edges");
      @(negedge rd_clk);
      chk(rd_data == 36'h3_C0DE_0042, "R7 fwft first word shown", rd_data, 36'h3_C0DE_0042);
      reader(1, 100);

      writer(DEPTH, 100);
      repeat (20) @(negedge wr_clk);
      chk(wr_ready == 1'b1, "R8 space after DEPTH writes", 36'(wr_ready), 36'd1);
      writer(1, 100);
      repeat (20) @(negedge wr_clk);
      chk(wr_ready == 1'b0, "R8 full after DEPTH+1 writes", 36'(wr_ready), 36'd0);
      reader(DEPTH + 1, 100);
      repeat (6) @(negedge rd_clk);
      chk(rd_ready == 1'b0, "R8 drained", 36'(rd_ready), 36'd0);

      fork
         writer(400, 70);
         reader(400, 40);
      join

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule